// File: doc/BRIEF.md
# Brown-out Reset Release Sequencer

This block decides when a device may leave reset after a power-on or a brown-out. It receives a brown-out flag from an external supply comparator and an asynchronous power-on flag. From these it drives an internal reset, a clock-hold signal, a code-execution enable and a sticky brown-out status bit.

After either event, the block first waits for the core regulator to settle. It then runs two branches side by side. The clock branch waits for the oscillator start-up count when a crystal is the selected source, and for PLL lock when the PLL is in use. The timer branch runs a programmable power-up delay. Reset is released one cycle after both branches are finished. When the device wakes from sleep, it sees the regulator settling wait again, without a reset. Brown-out detection stays active in sleep and idle.

Top module: `bor_release_seq`

## Requirements
- R1: While `por_i` is high, `rst_o` and `clk_hold_o` are 1, and `exec_en_o` and `bor_stat_o` are 0. After `por_i` falls, `rst_o` first reads 0 in the sample 1+REG_CYCLES+W after the fall, where W is the wait-phase length defined in R6.
- R2: `bor_i` passes through a two-flop synchronizer. `rst_o` rises in the third sample after `bor_i` rises and stays high while `bor_i` stays high. After `bor_i` falls, `rst_o` first reads 0 in sample 3+REG_CYCLES+W.
- R3: A regulator settling wait of REG_CYCLES cycles follows every reset exit. During this wait `rst_o` and `clk_hold_o` stay 1.
- R4: A crystal source is selected when `nosc_i` is 2 or 3 and `posc_mode_i` is 2'b01 or 2'b10. Values 2'b00 (external clock) and 2'b11 (off) are not crystals. With a crystal source, `clk_hold_o` stays 1 for OST_CYCLES cycles of the wait phase and drops in the sample REG_CYCLES+OST_CYCLES+3 after the brown-out flag falls.
- R5: The PLL is in use when `pll_en_i` is 1 and `nosc_i` is 1 or 3. In that case `clk_hold_o` and `rst_o` stay 1 until `pll_lock_i` reads 1, and reset drops in the next sample.
- R6: The power-up timer runs `pwrt_len_i` cycles at the same time as the clock branch. W = 1 + max(crystal ? OST_CYCLES : 0, timer length).
- R7: When `pwrt_len_i` is 0 and a crystal source is selected, the timer length is FSCM_CYCLES instead.
- R8: The clock and timer settings are captured on the edge that leaves the reset-assert state. Changes made after that edge do not affect the current release.
- R9: `bor_stat_o` is set by any synchronized brown-out and holds until a write with `stat_we_i`=1 and `stat_wdata_i`=0. A write of 1 has no effect. A clearing write in a cycle where the brown-out is still present has no effect.
- R10: A brown-out asserts reset even while `sleep_i` or `idle_i` is high. A brown-out during any wait phase restarts the whole sequence.
- R11: When `sleep_i` falls while the block is running, `exec_en_o` first reads 1 in sample 1+REG_CYCLES after the fall. `rst_o` stays 0 throughout.
- R12: `exec_en_o` is 1 only in the run state while `sleep_i` and `idle_i` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_i | input | 1 | Asynchronous power-on flag, active high |
| bor_i | input | 1 | Brown-out comparator flag, asynchronous |
| sleep_i | input | 1 | Device in sleep |
| idle_i | input | 1 | Device in idle |
| nosc_i | input | 3 | Clock source select |
| posc_mode_i | input | 2 | Primary oscillator mode |
| pll_en_i | input | 1 | PLL enable setting |
| pll_lock_i | input | 1 | PLL lock indication |
| pwrt_len_i | input | PWRT_W | Power-up timer length in cycles |
| stat_we_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 1 | Status write data |
| rst_o | output | 1 | Internal reset |
| clk_hold_o | output | 1 | System clock hold |
| exec_en_o | output | 1 | Code execution enable |
| bor_stat_o | output | 1 | Sticky brown-out status |

## Verification
The bench builds the block with REG_CYCLES=5, OST_CYCLES=12, FSCM_CYCLES=20 and PWRT_W=6. With these values a timer length (up to 63) can be shorter or longer than the start-up count. Both the case where the timer decides the release and the case where the start-up count decides it therefore fit in a few dozen cycles. They also place the early drop of clock hold, ahead of reset, within easy reach. The 20-cycle fallback is longer than the 12-cycle count, so the fallback's effect on release time can be observed directly.

// File: rtl/bor_release_seq.sv
module bor_release_seq #(
  parameter int REG_CYCLES  = 20,
  parameter int OST_CYCLES  = 64,
  parameter int FSCM_CYCLES = 100,
  parameter int PWRT_W      = 8
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              sleep_i,
  input  logic              idle_i,
  input  logic [2:0]        nosc_i,
  input  logic [1:0]        posc_mode_i,
  input  logic              pll_en_i,
  input  logic              pll_lock_i,
  input  logic [PWRT_W-1:0] pwrt_len_i,
  input  logic              stat_we_i,
  input  logic              stat_wdata_i,
  output logic              rst_o,
  output logic              clk_hold_o,
  output logic              exec_en_o,
  output logic              bor_stat_o
);

  localparam int PW_MAX = (1 << PWRT_W) - 1;
  localparam int M1     = (REG_CYCLES > OST_CYCLES) ? REG_CYCLES : OST_CYCLES;
  localparam int M2     = (M1 > FSCM_CYCLES) ? M1 : FSCM_CYCLES;
  localparam int MAXC   = (M2 > PW_MAX) ? M2 : PW_MAX;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(REG_CYCLES - 1);
  localparam logic [CNT_W-1:0] OST_N    = CNT_W'(OST_CYCLES);
  localparam logic [CNT_W-1:0] FSCM_N   = CNT_W'(FSCM_CYCLES);

  typedef enum logic [2:0] {S_ASSERT, S_REG, S_WAIT, S_RUN, S_RESUME} state_t;

  state_t           state;
  logic [1:0]       bor_sync;
  logic             sleep_q, xtal_q, pll_q, stat_q;
  logic [CNT_W-1:0] cnt, ost_cnt, pw_cnt, pw_tgt_q;

  wire bor_s    = bor_sync[1];
  wire xtal_sel = (nosc_i == 3'd2 || nosc_i == 3'd3) &&
                  (posc_mode_i == 2'b01 || posc_mode_i == 2'b10);
  wire pll_sel  = pll_en_i && (nosc_i == 3'd1 || nosc_i == 3'd3);
  wire [CNT_W-1:0] pw_tgt_d = (pwrt_len_i == '0 && xtal_sel) ? FSCM_N : CNT_W'(pwrt_len_i);

  wire ost_ok  = !xtal_q || ost_cnt == OST_N;
  wire lock_ok = !pll_q || pll_lock_i;
  wire pw_ok   = pw_cnt == pw_tgt_q;
  wire clk_ok  = ost_ok && lock_ok;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) bor_sync <= 2'b00;
    else       bor_sync <= {bor_sync[0], bor_i};
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      state    <= S_ASSERT;
      cnt      <= '0;
      ost_cnt  <= '0;
      pw_cnt   <= '0;
      pw_tgt_q <= '0;
      xtal_q   <= 1'b0;
      pll_q    <= 1'b0;
      sleep_q  <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      sleep_q <= sleep_i;
      if (bor_s)                          stat_q <= 1'b1;
      else if (stat_we_i && !stat_wdata_i) stat_q <= 1'b0;

      if (bor_s) begin
        state <= S_ASSERT;
      end else begin
        case (state)
          S_ASSERT: begin
            xtal_q   <= xtal_sel;
            pll_q    <= pll_sel;
            pw_tgt_q <= pw_tgt_d;
            cnt      <= '0;
            state    <= S_REG;
          end
          S_REG: begin
            if (cnt == REG_LAST) begin
              ost_cnt <= '0;
              pw_cnt  <= '0;
              state   <= S_WAIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WAIT: begin
            if (ost_cnt != OST_N)   ost_cnt <= ost_cnt + 1'b1;
            if (pw_cnt != pw_tgt_q) pw_cnt  <= pw_cnt + 1'b1;
            if (clk_ok && pw_ok)    state   <= S_RUN;
          end
          S_RUN: begin
            if (sleep_q && !sleep_i) begin
              cnt   <= '0;
              state <= S_RESUME;
            end
          end
          S_RESUME: begin
            if (cnt == REG_LAST) state <= S_RUN;
            else                 cnt   <= cnt + 1'b1;
          end
          default: state <= S_ASSERT;
        endcase
      end
    end
  end

  assign rst_o      = state == S_ASSERT || state == S_REG || state == S_WAIT;
  assign clk_hold_o = state == S_ASSERT || state == S_REG || (state == S_WAIT && !clk_ok);
  assign exec_en_o  = state == S_RUN && !sleep_i && !idle_i;
  assign bor_stat_o = stat_q;

  assert_bor_forces_reset_R2: assert property (@(posedge clk) disable iff (por_i)
    bor_s |=> (rst_o && bor_stat_o));

  assert_release_after_clock_R6: assert property (@(posedge clk) disable iff (por_i)
    $fell(rst_o) |-> !$past(clk_hold_o));

  assert_pll_locked_at_release_R5: assert property (@(posedge clk) disable iff (por_i)
    ($fell(rst_o) && $past(pll_q)) |-> $past(pll_lock_i));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (por_i)
    $fell(bor_stat_o) |-> $past(stat_we_i && !stat_wdata_i && !bor_s));

  assert_exec_only_released_R12: assert property (@(posedge clk) disable iff (por_i)
    exec_en_o |-> (!rst_o && !clk_hold_o));

  assert_resume_blocks_exec_R11: assert property (@(posedge clk) disable iff (por_i)
    ($fell(sleep_i) && !rst_o && !bor_s) |=> !exec_en_o);

endmodule

// File: tb/bor_release_seq_bench.sv
module bor_release_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REG = 5, OST = 12, FSCM = 20, PW = 6;

  logic clk = 1'b0;
  logic por_i, bor_i, sleep_i, idle_i, pll_en_i, pll_lock_i, stat_we_i, stat_wdata_i;
  logic [2:0] nosc_i;
  logic [1:0] posc_mode_i;
  logic [PW-1:0] pwrt_len_i;
  logic rst_o, clk_hold_o, exec_en_o, bor_stat_o;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bor_release_seq #(.REG_CYCLES(REG), .OST_CYCLES(OST), .FSCM_CYCLES(FSCM), .PWRT_W(PW)) u_bor_release_seq (
    .clk(clk), .por_i(por_i), .bor_i(bor_i), .sleep_i(sleep_i), .idle_i(idle_i),
    .nosc_i(nosc_i), .posc_mode_i(posc_mode_i), .pll_en_i(pll_en_i), .pll_lock_i(pll_lock_i),
    .pwrt_len_i(pwrt_len_i), .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i),
    .rst_o(rst_o), .clk_hold_o(clk_hold_o), .exec_en_o(exec_en_o), .bor_stat_o(bor_stat_o));

  // {nosc, posc, pll_en, pwrt, W}
  localparam logic [19:0] VEC [0:10] = '{
    {3'd0, 2'd3, 1'b0, 6'd0,  8'd1},
    {3'd0, 2'd3, 1'b0, 6'd7,  8'd8},
    {3'd2, 2'd1, 1'b0, 6'd3,  8'd13},
    {3'd2, 2'd2, 1'b0, 6'd30, 8'd31},
    {3'd2, 2'd0, 1'b0, 6'd0,  8'd1},
    {3'd3, 2'd1, 1'b0, 6'd0,  8'd21},
    {3'd2, 2'd1, 1'b0, 6'd0,  8'd21},
    {3'd1, 2'd3, 1'b1, 6'd4,  8'd5},
    {3'd5, 2'd1, 1'b0, 6'd0,  8'd1},
    {3'd2, 2'd3, 1'b0, 6'd0,  8'd1},
    {3'd3, 2'd2, 1'b1, 6'd0,  8'd21}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] n, input logic [1:0] p, input logic pl, input int pw);
    nosc_i = n; posc_mode_i = p; pll_en_i = pl; pwrt_len_i = PW'(pw);
  endtask

  task automatic measure(output int k);
    k = 0;
    do begin
      step(1);
      k++;
    end while (rst_o && k < 600);
  endtask

  task automatic bor_pulse;
    bor_i = 1'b1;
    step(4);
    bor_i = 1'b0;
  endtask

  task automatic clear_stat;
    stat_we_i = 1'b1; stat_wdata_i = 1'b0;
    step(1);
    stat_we_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int k;
    por_i = 1'b1; bor_i = 1'b0; sleep_i = 1'b0; idle_i = 1'b0; pll_lock_i = 1'b1;
    stat_we_i = 1'b0; stat_wdata_i = 1'b0;
    set_cfg(3'd0, 2'd3, 1'b0, 0);
    step(3);
    chk(rst_o && clk_hold_o && !exec_en_o && !bor_stat_o, "R1 por state",
        {rst_o, clk_hold_o, exec_en_o, bor_stat_o}, 4'b1100);
    por_i = 1'b0;
    measure(k);
    chk(k == 1 + REG + 1, "R1 por release", k, 1 + REG + 1);
    chk(exec_en_o && !clk_hold_o && !bor_stat_o, "R1 run state",
        {exec_en_o, clk_hold_o, bor_stat_o}, 3'b100);

    // R2 synchronizer latency and hold
    bor_i = 1'b1;
    step(2);
    chk(!rst_o, "R2 two-flop latency", rst_o, 0);
    step(1);
    chk(rst_o && bor_stat_o, "R2 reset on third sample", {rst_o, bor_stat_o}, 2'b11);
    step(10);
    chk(rst_o, "R2 held while flag high", rst_o, 1);
    bor_i = 1'b0;
    step(5);
    chk(rst_o && clk_hold_o && !exec_en_o, "R3 regulator wait",
        {rst_o, clk_hold_o, exec_en_o}, 3'b110);
    measure(k);
    chk(k + 5 == 3 + REG + 1, "R2 R3 release after flag falls", k + 5, 3 + REG + 1);

    // R9 write of 1 ignored, write of 0 clears
    stat_we_i = 1'b1; stat_wdata_i = 1'b1;
    step(1);
    chk(bor_stat_o, "R9 write of one ignored", bor_stat_o, 1);
    stat_wdata_i = 1'b0;
    step(1);
    stat_we_i = 1'b0;
    chk(!bor_stat_o, "R9 write of zero clears", bor_stat_o, 0);

    // vector table: R4 R5 R6 R7 release timing
    for (int i = 0; i < 11; i++) begin
      set_cfg(VEC[i][19:17], VEC[i][16:15], VEC[i][14], int'(VEC[i][13:8]));
      bor_pulse();
      measure(k);
      chk(k == 3 + REG + int'(VEC[i][7:0]), $sformatf("R4 R5 R6 R7 vector %0d", i),
          k, 3 + REG + int'(VEC[i][7:0]));
      chk(bor_stat_o, $sformatf("R9 status set vector %0d", i), bor_stat_o, 1);
      clear_stat();
    end

    // R4 clock hold drops before reset
    set_cfg(3'd2, 2'd1, 1'b0, 30);
    bor_pulse();
    step(3 + REG + OST - 1);
    chk(clk_hold_o, "R4 clock held during start-up count", clk_hold_o, 1);
    step(1);
    chk(!clk_hold_o && rst_o, "R4 clock free, reset held", {clk_hold_o, rst_o}, 2'b01);
    measure(k);
    chk(k + 3 + REG + OST == 3 + REG + 31, "R6 timer decides release", k + 3 + REG + OST, 3 + REG + 31);

    // R5 PLL lock gating
    set_cfg(3'd1, 2'd3, 1'b1, 0);
    pll_lock_i = 1'b0;
    bor_pulse();
    step(40);
    chk(rst_o && clk_hold_o, "R5 held without lock", {rst_o, clk_hold_o}, 2'b11);
    pll_lock_i = 1'b1;
    step(1);
    chk(!rst_o && !clk_hold_o, "R5 release after lock", {rst_o, clk_hold_o}, 2'b00);

    // R8 settings captured at reset exit
    set_cfg(3'd0, 2'd3, 1'b0, 0);
    bor_pulse();
    step(4);
    set_cfg(3'd2, 2'd1, 1'b0, 30);
    measure(k);
    chk(k + 4 == 3 + REG + 1, "R8 late config ignored", k + 4, 3 + REG + 1);

    // R10 restart during wait phase
    set_cfg(3'd0, 2'd3, 1'b0, 30);
    bor_pulse();
    step(3 + REG + 10);
    chk(rst_o, "R10 in wait phase", rst_o, 1);
    bor_pulse();
    measure(k);
    chk(k == 3 + REG + 31, "R10 full restart", k, 3 + REG + 31);
    clear_stat();

    // R10 brown-out in sleep, R11 resume, R12
    set_cfg(3'd0, 2'd3, 1'b0, 0);
    sleep_i = 1'b1;
    step(2);
    bor_i = 1'b1;
    step(3);
    chk(rst_o && bor_stat_o, "R10 brown-out during sleep", {rst_o, bor_stat_o}, 2'b11);
    bor_i = 1'b0;
    measure(k);
    chk(!exec_en_o, "R12 no execution in sleep", exec_en_o, 0);
    sleep_i = 1'b0;
    step(REG);
    chk(!exec_en_o && !rst_o, "R11 resume wait", {exec_en_o, rst_o}, 2'b00);
    step(1);
    chk(exec_en_o, "R11 execution after resume wait", exec_en_o, 1);
    idle_i = 1'b1;
    step(1);
    chk(!exec_en_o && !clk_hold_o, "R12 idle stops execution", {exec_en_o, clk_hold_o}, 2'b00);
    idle_i = 1'b0;
    step(1);
    chk(exec_en_o, "R12 idle released", exec_en_o, 1);

    // R9 set wins over clear; R10 brown-out in idle
    idle_i = 1'b1;
    bor_i = 1'b1;
    step(3);
    chk(rst_o, "R10 brown-out during idle", rst_o, 1);
    idle_i = 1'b0;
    stat_we_i = 1'b1; stat_wdata_i = 1'b0;
    step(2);
    stat_we_i = 1'b0;
    chk(bor_stat_o, "R9 set wins over clear", bor_stat_o, 1);
    bor_i = 1'b0;
    measure(k);
    chk(bor_stat_o && !rst_o, "R9 still set after release", {bor_stat_o, rst_o}, 2'b10);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule